// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger-Level Interrupts

This block sits between a word-wide register port and a serial bus engine. It holds two byte queues. The outbound queue is filled by register writes and drained by the engine. The inbound queue is filled by the engine and drained by register reads. Each queue has its own programmable threshold. The outbound queue raises an almost-empty condition when it runs low. The inbound queue raises an almost-full condition when it fills up.

A twelve-bit interrupt status register collects these events. It also collects overrun and underrun on both queues, a trailing-data timeout on the inbound queue, and five completion or error pulses from the engine. Software clears status bits by writing ones to them. A single interrupt line is the OR of the status bits that are enabled.

The trailing timeout covers the end of a read. The last few bytes may never reach the almost-full threshold. The timeout reports them once the engine has been silent for a programmed number of cycles.

Top module: `fifo_irq_hub`

## Requirements
- R1: Control word (register index 0) bit 0 enables the inbound queue and bit 1 enables the outbound queue. Bits 10:4 hold the inbound threshold and bits 22:16 hold the outbound threshold. A queue whose enable bit is 0 is emptied on the next clock edge. While it is disabled, pushes to it are discarded and raise no status bit.
- R2: Each queue returns bytes in the order they were pushed. A write to register index 4 pushes data bits 7:0 into the outbound queue, and `engTxData` shows its oldest byte. A read of register index 5 returns the oldest inbound byte in bits 7:0 and removes it.
- R3: The queue status word (register index 3) has the outbound level in bits 6:0, outbound full at bit 7 and outbound empty at bit 8. It has the inbound level in bits 22:16, inbound full at bit 23 and inbound empty at bit 24. All other bits are 0.
- R4: A push into a full queue is dropped and the level stays at DEPTH. It sets interrupt bit 3 for the outbound queue (register write) or bit 5 for the inbound queue (`engRxPush`).
- R5: A pop from an empty queue returns zero and sets interrupt bit 2 for the outbound queue (`engTxPop`) or bit 4 for the inbound queue (register read).
- R6: Interrupt bit 0 is set on each clock edge where the outbound queue is enabled and its level is less than or equal to the outbound threshold. Bit 1 is set on each edge where the inbound queue is enabled and its level is greater than or equal to the inbound threshold.
- R7: Register index 6 bits 3:0 hold an idle count N. The inbound queue may be enabled, non-empty and below its threshold. If it then receives no push for N+1 consecutive edges after its last push, interrupt bit 6 is set at that (N+1)-th edge. It is set once per idle stretch.
- R8: Pulses on `engEvt[4:0]` set interrupt bits 7 to 11 in order: done, abort, no-acknowledge, no-device, timeout.
- R9: Interrupt status (register index 2) clears the bits written as one. If a set condition is active in the same cycle, the set wins.
- R10: `irq` is the OR of interrupt status AND the interrupt enable mask (register index 1, bits 11:0). It follows the registers with no added delay.
- R11: After reset, every register is zero, both queues are empty, the queue status word reads 0x01000100 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops at index 5) |
| regAddr | input | 3 | Register index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| engTxPop | input | 1 | Engine takes the oldest outbound byte |
| engTxData | output | 8 | Oldest outbound byte, zero when empty |
| engRxPush | input | 1 | Engine delivers an inbound byte |
| engRxData | input | 8 | Inbound byte |
| engEvt | input | 5 | Engine completion and error pulses |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the trailing timeout at the exact edge. A counter that is off by one would raise the interrupt line one cycle early or late. It checks a write-one-to-clear that lands while the almost-empty condition still holds. A design that let the clear win would drop an event that is still pending. It overfills and over-drains both queues to catch a dropped byte that is written anyway, or an empty read that returns stale data. A long random mix of pushes and pops on both queues, compared against queue models, catches pointer wraparound and simultaneous push/pop errors.

// File: rtl/fih_pkg.sv
package fih_pkg;
  localparam int LVL_W  = 7;
  localparam int INT_W  = 12;
  localparam int ADDR_W = 3;
  localparam int EVT_W  = 5;

  localparam logic [ADDR_W-1:0] IDX_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_INTEN  = 3'd1;
  localparam logic [ADDR_W-1:0] IDX_INTST  = 3'd2;
  localparam logic [ADDR_W-1:0] IDX_QSTAT  = 3'd3;
  localparam logic [ADDR_W-1:0] IDX_TXDATA = 3'd4;
  localparam logic [ADDR_W-1:0] IDX_RXDATA = 3'd5;
  localparam logic [ADDR_W-1:0] IDX_TRAIL  = 3'd6;

  localparam logic [31:0] CTRL_MASK = 32'h007F_07F3;

  localparam int B_TX_LOW  = 0;
  localparam int B_RX_HIGH = 1;
  localparam int B_TX_UND  = 2;
  localparam int B_TX_OVF  = 3;
  localparam int B_RX_UND  = 4;
  localparam int B_RX_OVF  = 5;
  localparam int B_TRAIL   = 6;
  localparam int B_EVT0    = 7;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifo_strobe_t;
endpackage

// File: rtl/fih_byte_fifo.sv
module fih_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           wdata,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [LW-1:0]    count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wdata;
  end

  assign head  = (count == '0) ? '0 : mem[rdPtr];
  assign level = count;
endmodule

// File: rtl/fih_datapath.sv
module fih_datapath
  import fih_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifo_strobe_t           stb,
  input  logic [7:0]             txWdata,
  input  logic [7:0]             rxWdata,
  output logic [7:0]             txHead,
  output logic [7:0]             rxHead,
  output logic [$clog2(DEPTH):0] txLevel,
  output logic [$clog2(DEPTH):0] rxLevel
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [1:0]    chPush, chPop, chFlush;
  logic [7:0]    chWdata [2];
  logic [7:0]    chHead  [2];
  logic [LW-1:0] chLevel [2];

  assign chPush  = {stb.rxPush,  stb.txPush};
  assign chPop   = {stb.rxPop,   stb.txPop};
  assign chFlush = {stb.rxFlush, stb.txFlush};
  assign chWdata[0] = txWdata;
  assign chWdata[1] = rxWdata;

  for (genvar ch = 0; ch < 2; ch++) begin : g_queue
    fih_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .flush (chFlush[ch]),
      .push  (chPush[ch]),
      .pop   (chPop[ch]),
      .wdata (chWdata[ch]),
      .head  (chHead[ch]),
      .level (chLevel[ch])
    );
  end

  assign txHead  = chHead[0];
  assign rxHead  = chHead[1];
  assign txLevel = chLevel[0];
  assign rxLevel = chLevel[1];
endmodule

// File: rtl/fih_ctrl.sv
module fih_ctrl
  import fih_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic                   regRe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic [EVT_W-1:0]       engEvt,
  input  logic                   engTxPop,
  input  logic                   engRxPush,
  input  logic [$clog2(DEPTH):0] txLevel,
  input  logic [$clog2(DEPTH):0] rxLevel,
  input  logic [7:0]             rxHead,
  output fifo_strobe_t           stb,
  output logic [31:0]            ctrlQ,
  output logic [INT_W-1:0]       intStatus,
  output logic                   irq
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [INT_W-1:0] intEnable;
  logic [3:0]       trailCnt;
  logic [4:0]       idleCnt, idleNext;
  logic [INT_W-1:0] setVec, clrVec;

  logic rxEn, txEn;
  logic [LVL_W-1:0] rxTrig, txTrig, txLvl7, rxLvl7;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txPushReq, txPopReq, rxPushReq, rxPopReq;
  logic trailCond, trailFire;
  logic [31:0] qStatus;

  assign rxEn   = ctrlQ[0];
  assign txEn   = ctrlQ[1];
  assign rxTrig = ctrlQ[10:4];
  assign txTrig = ctrlQ[22:16];
  assign txLvl7 = LVL_W'(txLevel);
  assign rxLvl7 = LVL_W'(rxLevel);

  assign txFull  = (txLevel == FULL_LVL);
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == FULL_LVL);
  assign rxEmpty = (rxLevel == '0);

  assign txPushReq = regWe && (regAddr == IDX_TXDATA) && txEn;
  assign rxPopReq  = regRe && (regAddr == IDX_RXDATA) && rxEn;
  assign txPopReq  = engTxPop && txEn;
  assign rxPushReq = engRxPush && rxEn;

  always_comb begin
    stb.txPush  = txPushReq && !txFull;
    stb.txPop   = txPopReq && !txEmpty;
    stb.txFlush = !txEn;
    stb.rxPush  = rxPushReq && !rxFull;
    stb.rxPop   = rxPopReq && !rxEmpty;
    stb.rxFlush = !rxEn;
  end

  // Trailing-data idle counter: runs while data waits below threshold.
  assign trailCond = rxEn && !rxEmpty && (rxLvl7 < rxTrig);
  assign trailFire = trailCond && !rxPushReq && (idleCnt == {1'b0, trailCnt});

  always_comb begin
    if (rxPushReq || !trailCond)            idleNext = '0;
    else if (idleCnt <= {1'b0, trailCnt})   idleNext = idleCnt + 5'd1;
    else                                    idleNext = idleCnt;
  end

  always_comb begin
    setVec = '0;
    setVec[B_TX_LOW]  = txEn && (txLvl7 <= txTrig);
    setVec[B_RX_HIGH] = rxEn && (rxLvl7 >= rxTrig);
    setVec[B_TX_UND]  = txPopReq && txEmpty;
    setVec[B_TX_OVF]  = txPushReq && txFull;
    setVec[B_RX_UND]  = rxPopReq && rxEmpty;
    setVec[B_RX_OVF]  = rxPushReq && rxFull;
    setVec[B_TRAIL]   = trailFire;
    setVec[B_EVT0 +: EVT_W] = engEvt;
  end

  assign clrVec = (regWe && regAddr == IDX_INTST) ? regWdata[INT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      intEnable <= '0;
      intStatus <= '0;
      trailCnt  <= '0;
      idleCnt   <= '0;
    end else begin
      if (regWe && regAddr == IDX_CTRL)  ctrlQ     <= regWdata & CTRL_MASK;
      if (regWe && regAddr == IDX_INTEN) intEnable <= regWdata[INT_W-1:0];
      if (regWe && regAddr == IDX_TRAIL) trailCnt  <= regWdata[3:0];
      intStatus <= (intStatus & ~clrVec) | setVec;
      idleCnt   <= idleNext;
    end
  end

  assign qStatus = {7'd0, rxEmpty, rxFull, rxLvl7, 7'd0, txEmpty, txFull, txLvl7};

  always_comb begin
    case (regAddr)
      IDX_CTRL:   regRdata = ctrlQ;
      IDX_INTEN:  regRdata = {{(32-INT_W){1'b0}}, intEnable};
      IDX_INTST:  regRdata = {{(32-INT_W){1'b0}}, intStatus};
      IDX_QSTAT:  regRdata = qStatus;
      IDX_RXDATA: regRdata = {24'd0, rxEn ? rxHead : 8'd0};
      IDX_TRAIL:  regRdata = {28'd0, trailCnt};
      default:    regRdata = '0;
    endcase
  end

  assign irq = |(intStatus & intEnable);
endmodule

// File: rtl/fifo_irq_hub.sv
module fifo_irq_hub
  import fih_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        engTxPop,
  output logic [7:0]  engTxData,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData,
  input  logic [4:0]  engEvt,
  output logic        irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  fifo_strobe_t     stb;
  logic [LW-1:0]    txLevel, rxLevel;
  logic [7:0]       rxHead;
  logic [31:0]      ctrlQ;
  logic [INT_W-1:0] intStatus;

  fih_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regRe     (regRe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .engEvt    (engEvt),
    .engTxPop  (engTxPop),
    .engRxPush (engRxPush),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .rxHead    (rxHead),
    .stb       (stb),
    .ctrlQ     (ctrlQ),
    .intStatus (intStatus),
    .irq       (irq)
  );

  fih_datapath #(.DEPTH(DEPTH)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .txWdata (regWdata[7:0]),
    .rxWdata (engRxData),
    .txHead  (engTxData),
    .rxHead  (rxHead),
    .txLevel (txLevel),
    .rxLevel (rxLevel)
  );
endmodule

// File: rtl/fih_checker.sv
module fih_checker #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWe,
  input logic                   regRe,
  input logic [2:0]             regAddr,
  input logic                   clrAbort,
  input logic                   evtAbort,
  input logic                   engTxPop,
  input logic                   rxEn,
  input logic                   txEn,
  input logic [6:0]             txTrig,
  input logic [$clog2(DEPTH):0] txLevel,
  input logic [$clog2(DEPTH):0] rxLevel,
  input logic                   stTxLow,
  input logic                   stTxOvf,
  input logic                   stRxUnd,
  input logic                   stTrail,
  input logic                   stAbort
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= FULL_LVL) && (rxLevel <= FULL_LVL));

  assert_tx_overrun_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd4 && txEn && txLevel == FULL_LVL && !engTxPop)
      |=> (txLevel == FULL_LVL) && stTxOvf);

  assert_rx_underrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == 3'd5 && rxEn && rxLevel == '0) |=> stRxUnd);

  assert_tx_low_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && 7'(txLevel) <= txTrig) |=> stTxLow);

  assert_trail_has_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stTrail) |-> ($past(rxLevel) != '0));

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd2 && clrAbort && !evtAbort) |=> !stAbort);

  assert_disabled_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!txEn) |=> (txLevel == '0));
endmodule

bind fifo_irq_hub fih_checker #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regRe    (regRe),
  .regAddr  (regAddr),
  .clrAbort (regWdata[8]),
  .evtAbort (engEvt[1]),
  .engTxPop (engTxPop),
  .rxEn     (ctrlQ[0]),
  .txEn     (ctrlQ[1]),
  .txTrig   (ctrlQ[22:16]),
  .txLevel  (txLevel),
  .rxLevel  (rxLevel),
  .stTxLow  (intStatus[0]),
  .stTxOvf  (intStatus[3]),
  .stRxUnd  (intStatus[4]),
  .stTrail  (intStatus[6]),
  .stAbort  (intStatus[8])
);

// File: tb/fifo_irq_hub_tb.sv
`timescale 1ns/1ps
module fifo_irq_hub_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        engTxPop = 1'b0;
  logic [7:0]  engTxData;
  logic        engRxPush = 1'b0;
  logic [7:0]  engRxData = '0;
  logic [4:0]  engEvt = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  always #4 clk = ~clk;

  fifo_irq_hub #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engTxPop(engTxPop),
    .engTxData(engTxData), .engRxPush(engRxPush), .engRxData(engRxData),
    .engEvt(engEvt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    tick();
    regRe = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    engRxPush = 1'b1; engRxData = b;
    tick();
    engRxPush = 1'b0;
  endtask

  function automatic logic [31:0] qstat(input int tl, input int rl);
    return {7'd0, rl == 0, rl == DEPTH, 7'(rl), 7'd0, tl == 0, tl == DEPTH, 7'(tl)};
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R11: reset values
    regRead(3'd3, d); chk("R11 qstat", d, 32'h0100_0100);
    regRead(3'd2, d); chk("R11 intst", d, 32'h0);
    regRead(3'd0, d); chk("R11 ctrl", d, 32'h0);
    chk("R11 irq", {31'd0, irq}, 32'd0);

    // R1: disabled queues ignore pushes silently
    regWrite(3'd4, 32'h55);
    rxPush(8'h66);
    tick();
    regRead(3'd3, d); chk("R1 disabled stays empty", d, 32'h0100_0100);
    regRead(3'd2, d); chk("R1 no flags when disabled", d, 32'h0);

    // Enable: rx trig 4, tx trig 2
    regWrite(3'd0, 32'h3 | (32'd4 << 4) | (32'd2 << 16));
    regRead(3'd0, d); chk("R1 ctrl readback", d, 32'h0002_0043);
    regWrite(3'd4, 32'hA1); regWrite(3'd4, 32'hA2); regWrite(3'd4, 32'hA3);
    regRead(3'd3, d); chk("R3 tx level 3", d, qstat(3, 0));
    regWrite(3'd2, 32'h1);
    regRead(3'd2, d); chk("R9 clear tx-low above trigger", d & 32'h1, 32'h0);
    engTxPop = 1'b1; #1;
    chk("R2 tx head first", {24'd0, engTxData}, 32'hA1);
    tick(); engTxPop = 1'b0;
    tick();
    regRead(3'd2, d); chk("R6 tx-low at trigger", d & 32'h1, 32'h1);
    regWrite(3'd2, 32'h1);
    regRead(3'd2, d); chk("R9 set wins over clear", d & 32'h1, 32'h1);

    // Fill TX to full, overrun, drain, underrun
    for (int i = 0; i < DEPTH - 2; i++) regWrite(3'd4, 32'(8'h10 + i));
    regRead(3'd3, d); chk("R3 tx full word", d, qstat(DEPTH, 0));
    regWrite(3'd4, 32'hEE);
    regRead(3'd2, d); chk("R4 tx overrun flag", (d >> 3) & 1, 32'h1);
    regRead(3'd3, d); chk("R4 tx level held", d, qstat(DEPTH, 0));
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'hA2 : (i == 1) ? 8'hA3 : 8'(8'h10 + i - 2);
      engTxPop = 1'b1; #1;
      chk("R2 tx order", {24'd0, engTxData}, {24'd0, e});
      tick(); engTxPop = 1'b0;
    end
    chk("R5 tx empty data zero", {24'd0, engTxData}, 32'h0);
    engTxPop = 1'b1; tick(); engTxPop = 1'b0;
    regRead(3'd2, d); chk("R5 tx underrun flag", (d >> 2) & 1, 32'h1);
    regWrite(3'd2, 32'hFFF);

    // R7: trailing timeout with N=5, observed on irq
    regWrite(3'd6, 32'h5);
    regWrite(3'd1, 32'h40);
    rxPush(8'hB1); rxPush(8'hB2); rxPush(8'hB3);
    repeat (5) tick();
    chk("R7 trailing not yet", {31'd0, irq}, 32'd0);
    tick();
    chk("R7 trailing at N+1", {31'd0, irq}, 32'd1);
    rxPush(8'hB4);
    tick();
    regRead(3'd2, d); chk("R6 rx-high at trigger", (d >> 1) & 1, 32'h1);
    for (int i = 0; i < 4; i++) begin
      regRead(3'd5, d); chk("R2 rx order", d, 32'(8'hB1 + i));
    end
    regRead(3'd5, d); chk("R5 rx empty read zero", d, 32'h0);
    regRead(3'd2, d); chk("R5 rx underrun flag", (d >> 4) & 1, 32'h1);
    for (int i = 0; i <= DEPTH; i++) rxPush(8'(i));
    regRead(3'd2, d); chk("R4 rx overrun flag", (d >> 5) & 1, 32'h1);
    regRead(3'd3, d); chk("R4 rx level held", d, qstat(0, DEPTH));
    regWrite(3'd0, 32'h2 | (32'd2 << 16));
    tick();
    regRead(3'd3, d); chk("R1 disable flushes rx", d, qstat(0, 0));

    // R8: engine events
    regWrite(3'd1, 32'h0);
    regWrite(3'd2, 32'hFFF);
    for (int k = 0; k < 5; k++) begin
      engEvt = 5'(1 << k); tick(); engEvt = '0;
      regRead(3'd2, d); chk("R8 event bit", (d >> (7 + k)) & 1, 32'h1);
    end

    // R10: irq masking
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    regWrite(3'd1, 32'h100);
    chk("R10 irq enabled abort", {31'd0, irq}, 32'd1);
    regWrite(3'd2, 32'h100);
    chk("R10 irq after clear", {31'd0, irq}, 32'd0);

    // Random mix against queue models (R2, R3, R4, R5)
    regWrite(3'd0, 32'h0);
    regWrite(3'd0, 32'h3);
    txQ.delete(); rxQ.delete();
    for (int it = 0; it < 600; it++) begin
      int op;
      bit doPop, doRx, txOk, popOk, rxOk, rdOk;
      logic [7:0] wb, rb;
      op = int'($urandom % 3);
      doPop = 1'($urandom % 2);
      doRx  = 1'($urandom % 2);
      wb = 8'($urandom); rb = 8'($urandom);
      regWe = (op == 0); regRe = (op != 0);
      regAddr = (op == 0) ? 3'd4 : (op == 1) ? 3'd5 : 3'd3;
      regWdata = {24'd0, wb};
      engTxPop = doPop; engRxPush = doRx; engRxData = rb;
      #1;
      chk("R2 rand tx head", {24'd0, engTxData}, {24'd0, (txQ.size() > 0) ? txQ[0] : 8'h00});
      if (op == 1)
        chk("R2 rand rx head", regRdata, {24'd0, (rxQ.size() > 0) ? rxQ[0] : 8'h00});
      if (op == 2)
        chk("R3 rand levels", regRdata, qstat(txQ.size(), rxQ.size()));
      txOk  = (op == 0) && (txQ.size() < DEPTH);
      popOk = doPop && (txQ.size() > 0);
      rxOk  = doRx && (rxQ.size() < DEPTH);
      rdOk  = (op == 1) && (rxQ.size() > 0);
      if (popOk) void'(txQ.pop_front());
      if (txOk)  txQ.push_back(wb);
      if (rdOk)  void'(rxQ.pop_front());
      if (rxOk)  rxQ.push_back(rb);
      tick();
      regWe = 1'b0; regRe = 1'b0; engTxPop = 1'b0; engRxPush = 1'b0;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule